// File: doc/BRIEF.md
# Task File Register Address Decoder

This block sits between the host bus pins of a removable ATA storage card and its task file. It looks at the host address, the two active-low byte enables and the configured mode index. It then reports whether the access lands on a task file register and, if so, which one. It also says whether that register is the data port, and drives the active-low 16-bit transfer indicator for the host socket. The registers themselves live elsewhere. They consume `reg_sel_o` together with the host strobes.

Four address maps are supported, selected by the mode index: a memory map, a contiguous I/O map, and two fixed legacy I/O maps. A fifth map, the fixed-disk style mode, overrides the index. It is chosen once, at power-up, from the level of the output-enable pin. A one-cycle power-on strobe samples that pin into a latch. After that the latch holds its value whatever the pin does. While the latch is set, only address bits 2:0 and the two enables take part in decoding.

Register select encoding used by every map: 0h–7h are the eight main registers, with 0h the data port. 8h and 9h are the even and odd data-window bytes. Eh is the alternate-status/device-control pair. Fh is the drive-address register.

Top module: `tf_addr_decode`

## Requirements
- R1: While `rst_ni` is low and after it rises, `ide_mode_o` is 0, so the index-selected maps are in force.
- R2: On a rising `clk_i` edge with `por_i` high, `ide_mode_o` becomes the inverse of `oe_ni`. With `por_i` low it keeps its value whatever `oe_ni` does.
- R3: With both `ce1_ni` and `ce2_ni` high there is no hit in any mode.
- R4: Index 0 (memory map): effective addresses 000h–00Fh hit with select equal to address bits 3:0. Any address with bit 10 set hits the data window with select 8h (effective bit 0 clear) or 9h (set). Every other address misses.
- R5: Index 1 (contiguous I/O): every address hits, with select equal to effective address bits 3:0.
- R6: Index 2 (primary I/O): 1F0h–1F7h hit with select 0h–7h. 3F6h selects Eh and 3F7h selects Fh. All other addresses miss.
- R7: Index 3 (secondary I/O): 170h–177h hit with select 0h–7h. 376h selects Eh and 377h selects Fh. All other addresses miss.
- R8: Outside fixed-disk mode, index values 4 to 63 never hit.
- R9: Outside fixed-disk mode, an odd-byte-only access (`ce1_ni` high, `ce2_ni` low) decodes as if address bit 0 were 1.
- R10: In fixed-disk mode the index and address bits 10:3 are ignored. With `ce1_ni` low and `ce2_ni` high, select is address bits 2:0. With `ce1_ni` high, `ce2_ni` low and bits 2:0 equal 6h, select is Eh. Any other `ce2_ni`-only address misses, and both enables low misses.
- R11: `data_port_o` is 1 exactly when there is a hit with select 0h, 8h or 9h. On a miss, `reg_sel_o` is 0h and `data_port_o` is 0.
- R12: `iois16_no` is 0 exactly when `data_port_o` is 1 and either fixed-disk mode is set or both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the mode latch |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| por_i | input | 1 | Power-on sample strobe for the output-enable level |
| oe_ni | input | 1 | Sampled level of the host output-enable pin |
| mode_idx_i | input | 6 | Configured mode index |
| addr_i | input | 11 | Host address A10:A0 |
| ce1_ni | input | 1 | Even-byte enable, active low |
| ce2_ni | input | 1 | Odd-byte enable, active low |
| hit_o | output | 1 | Access targets a task file register |
| reg_sel_o | output | 4 | Register select code |
| data_port_o | output | 1 | Selected register is the data port |
| iois16_no | output | 1 | Active-low 16-bit data transfer indicator |
| ide_mode_o | output | 1 | Fixed-disk mode latched at power-up |

## Verification
The bench goes after the edges of each window. These are 1F7h against 1F8h, 3F5h against 3F6h, the swap of primary and secondary bases, and 3FFh against 400h in the memory map. A decoder that compared too few or too many address bits would hit one of these wrongly. Odd-byte-only accesses are aimed at the data port and the alternate pair, so a decoder that ignored the enable-driven bit 0 would return an even register. The latch is toggled through its pin with the strobe low, before and after entry into fixed-disk mode. It is also re-sampled back out of that mode, which exposes a latch that follows the pin. In fixed-disk mode, out-of-range index values and high address bits are driven to show that they are ignored.

// File: rtl/tf_dec_pkg.sv
package tf_dec_pkg;
  typedef enum logic [1:0] {
    MAP_MEM    = 2'd0,
    MAP_CONTIG = 2'd1,
    MAP_PRI    = 2'd2,
    MAP_SEC    = 2'd3
  } map_e;

  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_DATA     = 4'h0;
  localparam logic [SEL_W-1:0] SEL_WIN_EVEN = 4'h8;
  localparam logic [SEL_W-1:0] SEL_WIN_ODD  = 4'h9;
  localparam logic [SEL_W-1:0] SEL_ALT      = 4'hE;
  localparam logic [SEL_W-1:0] SEL_DRVADR   = 4'hF;
endpackage

// File: rtl/tf_ide_latch.sv
module tf_ide_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic oe_ni,
  output logic ide_o
);
  logic ide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ide_q <= 1'b0;
    else if (por_i) ide_q <= ~oe_ni;
  end

  assign ide_o = ide_q;

  AST_IDE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_i |=> $stable(ide_q)); // R2
  AST_IDE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (ide_q == !$past(oe_ni))); // R2
endmodule

// File: rtl/tf_io_window.sv
module tf_io_window
  import tf_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 11'h1F0,
  parameter logic [ADDR_W-1:0] ALT_BASE  = 11'h3F6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic main_hit, alt_hit;

  assign main_hit = addr_i[ADDR_W-1:3] == MAIN_BASE[ADDR_W-1:3];
  assign alt_hit  = addr_i[ADDR_W-1:1] == ALT_BASE[ADDR_W-1:1];
  assign hit_o    = main_hit | alt_hit;

  always_comb begin
    if (main_hit)     sel_o = {1'b0, addr_i[2:0]};
    else if (alt_hit) sel_o = addr_i[0] ? SEL_DRVADR : SEL_ALT;
    else              sel_o = '0;
  end

  always_comb begin
    AST_WIN_SEL_RANGE: assert (!hit_o || !sel_o[3] || sel_o[3:1] == 3'b111); // R6
  end
endmodule

// File: rtl/tf_pcmcia_decode.sv
module tf_pcmcia_decode
  import tf_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IDX_W  = 6,
  parameter logic [ADDR_W-1:0] PRI_BASE = 11'h1F0,
  parameter logic [ADDR_W-1:0] PRI_ALT  = 11'h3F6,
  parameter logic [ADDR_W-1:0] SEC_BASE = 11'h170,
  parameter logic [ADDR_W-1:0] SEC_ALT  = 11'h376
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_ni,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int unsigned N_IO = 2;

  logic [ADDR_W-1:0] eff_addr;
  logic              any_ce, idx_ok;
  logic              mem_lo, mem_win;
  logic [SEL_W-1:0]  mem_sel;
  logic [N_IO-1:0]   io_hit;
  logic [SEL_W-1:0]  io_sel [N_IO];
  map_e              map;

  // odd-byte-only cycle addresses the odd register of the pair
  assign eff_addr = {addr_i[ADDR_W-1:1], addr_i[0] | (ce1_ni & ~ce2_ni)};
  assign any_ce   = ~(ce1_ni & ce2_ni);
  assign idx_ok   = idx_i[IDX_W-1:2] == '0;
  assign map      = map_e'(idx_i[1:0]);

  assign mem_lo  = eff_addr[ADDR_W-2:4] == '0 && !eff_addr[ADDR_W-1];
  assign mem_win = eff_addr[ADDR_W-1];
  assign mem_sel = mem_win ? (eff_addr[0] ? SEL_WIN_ODD : SEL_WIN_EVEN)
                           : eff_addr[3:0];

  for (genvar g = 0; g < N_IO; g++) begin : g_io
    localparam logic [ADDR_W-1:0] MB = (g == 0) ? PRI_BASE : SEC_BASE;
    localparam logic [ADDR_W-1:0] AB = (g == 0) ? PRI_ALT  : SEC_ALT;
    tf_io_window #(
      .ADDR_W   (ADDR_W),
      .MAIN_BASE(MB),
      .ALT_BASE (AB)
    ) u_win (
      .addr_i(eff_addr),
      .hit_o (io_hit[g]),
      .sel_o (io_sel[g])
    );
  end

  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    if (any_ce && idx_ok) begin
      unique case (map)
        MAP_MEM: begin
          hit_o = mem_lo | mem_win;
          sel_o = (mem_lo | mem_win) ? mem_sel : '0;
        end
        MAP_CONTIG: begin
          hit_o = 1'b1;
          sel_o = eff_addr[3:0];
        end
        MAP_PRI: begin
          hit_o = io_hit[0];
          sel_o = io_sel[0];
        end
        MAP_SEC: begin
          hit_o = io_hit[1];
          sel_o = io_sel[1];
        end
      endcase
    end
  end

  always_comb begin
    AST_PC_IDX_MISS: assert (idx_ok || !hit_o); // R8
  end
endmodule

// File: rtl/tf_ide_window.sv
module tf_ide_window
  import tf_dec_pkg::*;
(
  input  logic             ce1_ni,
  input  logic             ce2_ni,
  input  logic [2:0]       addr_i,
  output logic             hit_o,
  output logic [SEL_W-1:0] sel_o
);
  logic main_acc, ctl_acc;

  assign main_acc = ~ce1_ni & ce2_ni;
  assign ctl_acc  = ce1_ni & ~ce2_ni & (addr_i == 3'd6);
  assign hit_o    = main_acc | ctl_acc;

  always_comb begin
    if (main_acc)     sel_o = {1'b0, addr_i};
    else if (ctl_acc) sel_o = SEL_ALT;
    else              sel_o = '0;
  end

  always_comb begin
    AST_IDE_BOTH_CE: assert (ce1_ni || ce2_ni || !hit_o); // R10
  end
endmodule

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
  import tf_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              oe_ni,
  input  logic [IDX_W-1:0]  mode_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_ni,
  output logic              hit_o,
  output logic [SEL_W-1:0]  reg_sel_o,
  output logic              data_port_o,
  output logic              iois16_no,
  output logic              ide_mode_o
);
  logic             ide;
  logic             pc_hit, ide_hit;
  logic [SEL_W-1:0] pc_sel, ide_sel;

  tf_ide_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .por_i (por_i),
    .oe_ni (oe_ni),
    .ide_o (ide)
  );

  tf_pcmcia_decode #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_pc (
    .idx_i (mode_idx_i),
    .addr_i(addr_i),
    .ce1_ni(ce1_ni),
    .ce2_ni(ce2_ni),
    .hit_o (pc_hit),
    .sel_o (pc_sel)
  );

  tf_ide_window u_ide (
    .ce1_ni(ce1_ni),
    .ce2_ni(ce2_ni),
    .addr_i(addr_i[2:0]),
    .hit_o (ide_hit),
    .sel_o (ide_sel)
  );

  assign hit_o       = ide ? ide_hit : pc_hit;
  assign reg_sel_o   = ide ? ide_sel : pc_sel;
  assign data_port_o = hit_o & (reg_sel_o == SEL_DATA ||
                                reg_sel_o == SEL_WIN_EVEN ||
                                reg_sel_o == SEL_WIN_ODD);
  assign iois16_no   = ~(data_port_o & (ide | (~ce1_ni & ~ce2_ni)));
  assign ide_mode_o  = ide;

  AST_NO_CE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni && ce2_ni) |-> !hit_o); // R3
  AST_MISS_SEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (reg_sel_o == '0 && !data_port_o)); // R11
  AST_IOIS16_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iois16_no |-> data_port_o); // R12
  AST_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ide_mode_o && mode_idx_i > 3) |-> !hit_o); // R8
  AST_IDE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ide_mode_o && !ce1_ni && !ce2_ni) |-> !hit_o); // R10
endmodule

// File: tb/tf_addr_decode_bench.sv
module tf_addr_decode_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        por_i = 1'b0;
  logic        oe_ni = 1'b1;
  logic [5:0]  mode_idx_i = '0;
  logic [10:0] addr_i = '0;
  logic        ce1_ni = 1'b1;
  logic        ce2_ni = 1'b1;
  logic        hit_o, data_port_o, iois16_no, ide_mode_o;
  logic [3:0]  reg_sel_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tf_addr_decode u_tf_addr_decode (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por_i), .oe_ni(oe_ni),
    .mode_idx_i(mode_idx_i), .addr_i(addr_i), .ce1_ni(ce1_ni), .ce2_ni(ce2_ni),
    .hit_o(hit_o), .reg_sel_o(reg_sel_o), .data_port_o(data_port_o),
    .iois16_no(iois16_no), .ide_mode_o(ide_mode_o)
  );

  // {idx, addr, ce1_n, ce2_n, hit, sel, data_port, iois16_n}
  localparam int NP = 30;
  localparam logic [25:0] PC_VEC [0:NP-1] = '{
    {6'd0,  11'h000, 2'b01, 1'b1, 4'h0, 1'b1, 1'b1}, // R4
    {6'd0,  11'h000, 2'b00, 1'b1, 4'h0, 1'b1, 1'b0}, // R12
    {6'd0,  11'h007, 2'b01, 1'b1, 4'h7, 1'b0, 1'b1}, // R4
    {6'd0,  11'h00F, 2'b01, 1'b1, 4'hF, 1'b0, 1'b1}, // R4
    {6'd0,  11'h010, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R4 R11
    {6'd0,  11'h400, 2'b00, 1'b1, 4'h8, 1'b1, 1'b0}, // R4
    {6'd0,  11'h7FF, 2'b01, 1'b1, 4'h9, 1'b1, 1'b1}, // R4
    {6'd0,  11'h3FF, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R4
    {6'd0,  11'h008, 2'b10, 1'b1, 4'h9, 1'b1, 1'b1}, // R9
    {6'd1,  11'h5A3, 2'b01, 1'b1, 4'h3, 1'b0, 1'b1}, // R5
    {6'd1,  11'h7F0, 2'b00, 1'b1, 4'h0, 1'b1, 1'b0}, // R5
    {6'd1,  11'h128, 2'b10, 1'b1, 4'h9, 1'b1, 1'b1}, // R9
    {6'd2,  11'h1F0, 2'b00, 1'b1, 4'h0, 1'b1, 1'b0}, // R6
    {6'd2,  11'h1F7, 2'b01, 1'b1, 4'h7, 1'b0, 1'b1}, // R6
    {6'd2,  11'h3F6, 2'b01, 1'b1, 4'hE, 1'b0, 1'b1}, // R6
    {6'd2,  11'h3F7, 2'b01, 1'b1, 4'hF, 1'b0, 1'b1}, // R6
    {6'd2,  11'h1F8, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R6
    {6'd2,  11'h3F5, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R6
    {6'd2,  11'h170, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R6
    {6'd3,  11'h170, 2'b01, 1'b1, 4'h0, 1'b1, 1'b1}, // R7
    {6'd3,  11'h177, 2'b01, 1'b1, 4'h7, 1'b0, 1'b1}, // R7
    {6'd3,  11'h376, 2'b01, 1'b1, 4'hE, 1'b0, 1'b1}, // R7
    {6'd3,  11'h377, 2'b01, 1'b1, 4'hF, 1'b0, 1'b1}, // R7
    {6'd3,  11'h1F0, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R7
    {6'd2,  11'h1F2, 2'b10, 1'b1, 4'h3, 1'b0, 1'b1}, // R9
    {6'd4,  11'h000, 2'b00, 1'b0, 4'h0, 1'b0, 1'b1}, // R8
    {6'd63, 11'h1F0, 2'b01, 1'b0, 4'h0, 1'b0, 1'b1}, // R8
    {6'd0,  11'h000, 2'b11, 1'b0, 4'h0, 1'b0, 1'b1}, // R3
    {6'd2,  11'h1F0, 2'b11, 1'b0, 4'h0, 1'b0, 1'b1}, // R3
    {6'd1,  11'h000, 2'b11, 1'b0, 4'h0, 1'b0, 1'b1}  // R3
  };
  localparam int PC_REQ [0:NP-1] = '{4,12,4,4,4,4,4,4,9,5,5,9,6,6,6,6,6,6,6,
                                     7,7,7,7,7,9,8,8,3,3,3};

  localparam int NI = 8;
  localparam logic [25:0] IDE_VEC [0:NI-1] = '{
    {6'd0, 11'h000, 2'b01, 1'b1, 4'h0, 1'b1, 1'b0}, // R10 R12
    {6'd3, 11'h7F5, 2'b01, 1'b1, 4'h5, 1'b0, 1'b1}, // R10
    {6'd1, 11'h006, 2'b10, 1'b1, 4'hE, 1'b0, 1'b1}, // R10
    {6'd0, 11'h3F6, 2'b10, 1'b1, 4'hE, 1'b0, 1'b1}, // R10
    {6'd0, 11'h007, 2'b10, 1'b0, 4'h0, 1'b0, 1'b1}, // R10
    {6'd0, 11'h000, 2'b00, 1'b0, 4'h0, 1'b0, 1'b1}, // R10
    {6'd0, 11'h000, 2'b11, 1'b0, 4'h0, 1'b0, 1'b1}, // R3
    {6'd5, 11'h003, 2'b01, 1'b1, 4'h3, 1'b0, 1'b1}  // R10
  };
  localparam int IDE_REQ [0:NI-1] = '{10,10,10,10,10,10,3,10};

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [25:0] v, input int req);
    @(negedge clk);
    mode_idx_i = v[25:20];
    addr_i     = v[19:9];
    ce1_ni     = v[8];
    ce2_ni     = v[7];
    #1;
    check(req, $sformatf("hit idx=%0d addr=%0h", v[25:20], v[19:9]), 32'(hit_o), 32'(v[6]));
    check(req, "reg_sel", 32'(reg_sel_o), 32'(v[5:2]));
    check(req, "data_port", 32'(data_port_o), 32'(v[1]));
    check(req, "iois16_n", 32'(iois16_no), 32'(v[0]));
  endtask

  task automatic strobe_por(input logic oe_level);
    @(negedge clk);
    oe_ni = oe_level;
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, "ide_mode in reset", 32'(ide_mode_o), 32'd0); // R1
    rst_ni = 1'b1;
    @(negedge clk);
    check(1, "ide_mode after reset", 32'(ide_mode_o), 32'd0); // R1

    strobe_por(1'b1);
    check(2, "por with oe high", 32'(ide_mode_o), 32'd0); // R2

    for (int i = 0; i < NP; i++) apply(PC_VEC[i], PC_REQ[i]);

    // R2: pin low without strobe must not enter fixed-disk mode
    @(negedge clk); oe_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(2, "oe low without por", 32'(ide_mode_o), 32'd0);
    apply(PC_VEC[2], 2);

    strobe_por(1'b0);
    check(2, "por with oe low", 32'(ide_mode_o), 32'd1); // R2

    for (int i = 0; i < NI; i++) apply(IDE_VEC[i], IDE_REQ[i]);

    // R2: pin high without strobe keeps fixed-disk mode
    @(negedge clk); oe_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(2, "oe high without por", 32'(ide_mode_o), 32'd1);
    apply(IDE_VEC[7], 2);

    strobe_por(1'b1);
    check(2, "por back to oe high", 32'(ide_mode_o), 32'd0); // R2
    apply(PC_VEC[26], 8);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule